// File: doc/BRIEF.md
# Auto-increment word program sequencer

This block programs a run of bytes into a serial flash that offers an auto-address-increment word program mode. A start pulse latches a start address and a byte count. The block first confirms that the device is idle and sets the write enable latch. If the start address is odd, it programs one byte on its own. It then streams the aligned body two bytes per frame, with only the first word frame carrying the address. It leaves the mode with a write disable. A last odd byte is written with its own enable, single-byte program and disable. Between program steps it polls the device status until the busy flag clears. If the device stays busy for too many reads, the remaining steps are abandoned and an error is flagged.

The block does not shift bits. It hands whole bytes to a byte-level SPI master through a valid/ready port. A frame-end flag tells the master to release chip select after that byte. The master returns the byte received during each transfer on `spi_rx`. That byte must be valid in the cycle the transfer is accepted. Payload bytes arrive on a valid/ready stream and pass straight through to the SPI port. A payload byte is consumed only in the cycle the master accepts it. The source must hold `din_valid` and `din_byte` steady until `din_ready` rises. The master may hold `spi_ready` low for any number of cycles. While it does, the frame stalls with chip select kept active. `start` is a plain level sampled only while the block is idle. `done` and `error` are single-cycle status pulses.

Top module: `aai_word_prog`

## Requirements
- R1: After reset, `spi_valid`, `din_ready`, `done` and `error` are low and `wr_count` is zero.
- R2: A run with nonzero length begins with one or more status-read frames until the device reads idle. It then sends the one-byte write enable frame 0x06.
- R3: When the start address is odd, the next frame is a single-byte program: 0x02, the address as ADDR_BYTES bytes most significant first, then one payload byte. After the status polling that follows it, the working address advances by one.
- R4: The aligned body goes out as word frames. The first is 0xAD, the working address (most significant byte first), then two payload bytes. Every later word frame is 0xAD followed by two payload bytes only, and the address advances by two per word.
- R5: After every program frame (0x02 or 0xAD), the block repeats a two-byte status frame (0x05 then 0x00, chip select released after the second byte). It stops when bit BUSY_BIT (bit 0 by default) of the byte received on the second transfer reads 0.
- R6: When no full word remains, a one-byte write disable frame 0x04 is sent, followed by status polling until idle.
- R7: If one byte remains after the body, the block sends 0x06, then 0x02 with the address start+length-1 and that byte, then status polling, then 0x04.
- R8: If POLL_LIMIT consecutive status reads within one wait all report busy, no further frame is sent, and `done` and `error` pulse together.
- R9: `done` is high for exactly one cycle per accepted start, after the final frame. `error` is never high without `done`.
- R10: `wr_count` clears when a start is accepted and rises by one for each payload byte accepted. Opcode, address, dummy and status bytes are not counted.
- R11: A start with length 0 sends no frame, consumes no payload, and pulses `done` without `error`.
- R12: A `start` raised while a run is in progress has no effect on the frames sent.
- R13: A payload byte is taken only in a cycle where it is also the byte accepted on the SPI port. Each run consumes exactly as many payload bytes as it programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| start_addr | input | 8*ADDR_BYTES | First flash byte address |
| length | input | LEN_W | Number of payload bytes |
| din_valid | input | 1 | Payload byte available |
| din_ready | output | 1 | Payload byte taken this cycle |
| din_byte | input | 8 | Payload byte |
| spi_valid | output | 1 | Byte offered to the SPI master |
| spi_ready | input | 1 | SPI master accepts the byte |
| spi_tx | output | 8 | Byte to shift out |
| spi_end | output | 1 | Release chip select after this byte |
| spi_rx | input | 8 | Byte shifted in during the accepted transfer |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Status wait timed out (with done) |
| wr_count | output | LEN_W | Payload bytes written this run |

## Verification
The SPI frame that follows a step begins at the earliest one cycle after the accepted byte that closed the previous frame. The bench therefore records each byte at the clock edge where valid and ready are both high. It compares whole frames, in order, against a list built from the requirements, so no cycle count has to be assumed. `done` and `error` are due on the cycle after the final accepted byte, or the cycle after the accepted start when the length is zero. The bench samples them on the falling edge. It then counts how many cycles `done` stays high and checks that no frame follows it. `wr_count` is read after `done`, when it has settled.

// File: rtl/aai_pkg.sv
package aai_pkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_BP   = 8'h02;
  localparam logic [7:0] OPC_AAI  = 8'hAD;

  // Describes one chip-select frame for the byte emitter.
  typedef struct packed {
    logic [7:0] op;        // first byte of the frame
    logic       use_addr;  // address bytes follow the opcode
    logic [1:0] ndata;     // payload bytes after opcode/address (0..2)
    logic       poll;      // status read: one dummy byte follows
  } frame_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_OP,
    PH_ADDR,
    PH_DATA
  } phase_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_POLL,
    S_WREN,
    S_HEAD,
    S_WORD,
    S_WRDI,
    S_WREN2,
    S_TAIL,
    S_WRDI2,
    S_FIN
  } seq_t;

endpackage

// File: rtl/aai_frame_tx.sv
module aai_frame_tx
  import aai_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int BUSY_BIT   = 0,
  localparam int AW        = 8 * ADDR_BYTES,
  localparam int IW        = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  frame_t        desc,
  input  logic [AW-1:0] addr,
  output logic          spi_valid,
  input  logic          spi_ready,
  output logic [7:0]    spi_tx,
  output logic          spi_end,
  input  logic [7:0]    spi_rx,
  input  logic          din_valid,
  output logic          din_ready,
  input  logic [7:0]    din_byte,
  output logic          fdone,
  output logic          fbusy
);

  localparam logic [IW-1:0] LAST_A    = IW'(ADDR_BYTES - 1);
  localparam logic [7:0]    BUSY_MASK = 8'(1 << BUSY_BIT);

  phase_t        ph;
  logic [IW-1:0] idx;
  logic          in_read;   // second byte of a status frame
  logic          hs;
  logic [IW:0]   idx_p1;
  logic [7:0]    abyte [ADDR_BYTES];

  // Address bytes, most significant first.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    assign abyte[g] = addr[AW-1-8*g -: 8];
  end

  assign idx_p1 = {1'b0, idx} + 1'b1;
  assign hs     = spi_valid && spi_ready;
  assign fdone  = hs && spi_end;
  assign fbusy  = |(spi_rx & BUSY_MASK);

  always_comb begin
    spi_valid = 1'b0;
    spi_tx    = 8'h00;
    spi_end   = 1'b0;
    din_ready = 1'b0;
    unique case (ph)
      PH_OP: begin
        spi_valid = 1'b1;
        spi_tx    = in_read ? 8'h00 : desc.op;
        spi_end   = in_read ||
                    (!desc.use_addr && desc.ndata == 2'd0 && !desc.poll);
      end
      PH_ADDR: begin
        spi_valid = 1'b1;
        spi_tx    = abyte[idx];
        spi_end   = (idx == LAST_A) && (desc.ndata == 2'd0);
      end
      PH_DATA: begin
        spi_valid = din_valid;
        spi_tx    = din_byte;
        din_ready = spi_ready;
        spi_end   = (idx_p1 == (IW+1)'(desc.ndata));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      idx     <= '0;
      in_read <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (req) begin
            ph      <= PH_OP;
            idx     <= '0;
            in_read <= 1'b0;
          end
        end
        PH_OP: begin
          if (hs) begin
            idx <= '0;
            if (spi_end) begin
              ph      <= PH_IDLE;
              in_read <= 1'b0;
            end else if (desc.poll) begin
              in_read <= 1'b1;
            end else if (desc.use_addr) begin
              ph <= PH_ADDR;
            end else begin
              ph <= PH_DATA;
            end
          end
        end
        PH_ADDR: begin
          if (hs) begin
            if (idx == LAST_A) begin
              idx <= '0;
              ph  <= spi_end ? PH_IDLE : PH_DATA;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (hs) begin
            if (spi_end) begin
              ph  <= PH_IDLE;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aai_poll_guard.sv
module aai_poll_guard #(
  parameter int POLL_LIMIT = 4096,
  localparam int CW        = $clog2(POLL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic last_try
);

  logic [CW-1:0] cnt;

  assign last_try = (cnt == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (hit) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/aai_cursor.sv
module aai_cursor #(
  parameter int AW    = 24,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    addr_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             adv1,
  input  logic             adv2,
  output logic [AW-1:0]    addr,
  output logic [LEN_W-1:0] rem,
  output logic             odd,
  output logic             rem_ge2,
  output logic             rem_gt2,
  output logic             rem_gt3,
  output logic             rem_one
);

  assign odd     = addr[0];
  assign rem_ge2 = rem >= LEN_W'(2);
  assign rem_gt2 = rem >  LEN_W'(2);
  assign rem_gt3 = rem >  LEN_W'(3);
  assign rem_one = rem == LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      rem  <= '0;
    end else if (load) begin
      addr <= addr_in;
      rem  <= len_in;
    end else if (adv2) begin
      addr <= addr + AW'(2);
      rem  <= rem - LEN_W'(2);
    end else if (adv1) begin
      addr <= addr + AW'(1);
      rem  <= rem - LEN_W'(1);
    end
  end

endmodule

// File: rtl/aai_word_prog.sv
module aai_word_prog
  import aai_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 16,
  parameter int POLL_LIMIT = 4096,
  parameter int BUSY_BIT   = 0,
  localparam int AW        = 8 * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic [LEN_W-1:0] length,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_byte,
  output logic             spi_valid,
  input  logic             spi_ready,
  output logic [7:0]       spi_tx,
  output logic             spi_end,
  input  logic [7:0]       spi_rx,
  output logic             done,
  output logic             error,
  output logic [LEN_W-1:0] wr_count
);

  seq_t          state;
  seq_t          ret_q;       // where a finished status wait resumes
  logic          first_q;     // next word frame carries the address
  logic          err_q;
  frame_t        desc;
  logic          req;
  logic          fdone;
  logic          fbusy;
  logic          take;
  logic          g_clr;
  logic          g_hit;
  logic          last_try;
  logic          c_load;
  logic          c_adv1;
  logic          c_adv2;
  logic [AW-1:0] cur_addr;
  logic [LEN_W-1:0] rem;
  logic          odd;
  logic          rem_ge2;
  logic          rem_gt2;
  logic          rem_gt3;
  logic          rem_one;
  logic          accept;

  assign accept = (state == S_IDLE) && start;
  assign req    = (state != S_IDLE) && (state != S_FIN);
  assign take   = din_valid && din_ready;
  assign done   = (state == S_FIN);
  assign error  = (state == S_FIN) && err_q;

  // Frame descriptor for the current step.
  always_comb begin
    desc = '{op: OPC_WREN, use_addr: 1'b0, ndata: 2'd0, poll: 1'b0};
    unique case (state)
      S_POLL:          desc = '{op: OPC_RDSR, use_addr: 1'b0, ndata: 2'd0, poll: 1'b1};
      S_WREN, S_WREN2: desc = '{op: OPC_WREN, use_addr: 1'b0, ndata: 2'd0, poll: 1'b0};
      S_HEAD, S_TAIL:  desc = '{op: OPC_BP,   use_addr: 1'b1, ndata: 2'd1, poll: 1'b0};
      S_WORD:          desc = '{op: OPC_AAI,  use_addr: first_q, ndata: 2'd2, poll: 1'b0};
      S_WRDI, S_WRDI2: desc = '{op: OPC_WRDI, use_addr: 1'b0, ndata: 2'd0, poll: 1'b0};
      default: ;
    endcase
  end

  // Side effects that the cursor and guard take on frame completion.
  always_comb begin
    c_load = accept;
    c_adv1 = fdone && ((state == S_HEAD) || (state == S_TAIL));
    c_adv2 = fdone && (state == S_WORD);
    g_clr  = accept || (fdone && (state == S_POLL) && !fbusy);
    g_hit  = fdone && (state == S_POLL) && fbusy && !last_try;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ret_q   <= S_IDLE;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            first_q <= 1'b1;
            err_q   <= 1'b0;
            ret_q   <= S_WREN;
            state   <= (length == '0) ? S_FIN : S_POLL;
          end
        end
        S_POLL: begin
          if (fdone) begin
            if (!fbusy) begin
              state <= ret_q;
            end else if (last_try) begin
              err_q <= 1'b1;
              state <= S_FIN;
            end
          end
        end
        S_WREN: begin
          if (fdone) begin
            if (odd)          state <= S_HEAD;
            else if (rem_ge2) state <= S_WORD;
            else              state <= S_WRDI;
          end
        end
        S_HEAD: begin
          if (fdone) begin
            state <= S_POLL;
            ret_q <= rem_gt2 ? S_WORD : S_WRDI;
          end
        end
        S_WORD: begin
          if (fdone) begin
            first_q <= 1'b0;
            state   <= S_POLL;
            ret_q   <= rem_gt3 ? S_WORD : S_WRDI;
          end
        end
        S_WRDI: begin
          if (fdone) begin
            state <= S_POLL;
            ret_q <= rem_one ? S_WREN2 : S_FIN;
          end
        end
        S_WREN2: if (fdone) state <= S_TAIL;
        S_TAIL: begin
          if (fdone) begin
            state <= S_POLL;
            ret_q <= S_WRDI2;
          end
        end
        S_WRDI2: if (fdone) state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_count <= '0;
    end else if (accept) begin
      wr_count <= '0;
    end else if (take) begin
      wr_count <= wr_count + 1'b1;
    end
  end

  aai_cursor #(
    .AW    (AW),
    .LEN_W (LEN_W)
  ) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (c_load),
    .addr_in (start_addr),
    .len_in  (length),
    .adv1    (c_adv1),
    .adv2    (c_adv2),
    .addr    (cur_addr),
    .rem     (rem),
    .odd     (odd),
    .rem_ge2 (rem_ge2),
    .rem_gt2 (rem_gt2),
    .rem_gt3 (rem_gt3),
    .rem_one (rem_one)
  );

  aai_poll_guard #(
    .POLL_LIMIT (POLL_LIMIT)
  ) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (g_clr),
    .hit      (g_hit),
    .last_try (last_try)
  );

  aai_frame_tx #(
    .ADDR_BYTES (ADDR_BYTES),
    .BUSY_BIT   (BUSY_BIT)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .desc      (desc),
    .addr      (cur_addr),
    .spi_valid (spi_valid),
    .spi_ready (spi_ready),
    .spi_tx    (spi_tx),
    .spi_end   (spi_end),
    .spi_rx    (spi_rx),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .din_byte  (din_byte),
    .fdone     (fdone),
    .fbusy     (fbusy)
  );

endmodule

// File: rtl/aai_word_prog_chk.sv
module aai_word_prog_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             din_valid,
  input logic             din_ready,
  input logic [7:0]       din_byte,
  input logic             spi_valid,
  input logic             spi_ready,
  input logic [7:0]       spi_tx,
  input logic             done,
  input logic             error,
  input logic [LEN_W-1:0] wr_count
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                            // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);                                            // R9

  AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!spi_valid && !din_ready));                       // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count != $past(wr_count)) |->
      ((wr_count == $past(wr_count) + 1'b1) || (wr_count == '0))); // R10

  AST_DIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |->
      (spi_valid && spi_ready && (spi_tx == din_byte)));        // R13

endmodule

bind aai_word_prog aai_word_prog_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din_valid (din_valid),
  .din_ready (din_ready),
  .din_byte  (din_byte),
  .spi_valid (spi_valid),
  .spi_ready (spi_ready),
  .spi_tx    (spi_tx),
  .done      (done),
  .error     (error),
  .wr_count  (wr_count)
);

// File: tb/sim_aai_word_prog.sv
module sim_aai_word_prog;

  localparam int LIM = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [15:0] length = '0;
  logic        din_valid;
  logic        din_ready;
  logic [7:0]  din_byte;
  logic        spi_valid;
  logic        spi_ready = 1'b0;
  logic [7:0]  spi_tx;
  logic        spi_end;
  logic [7:0]  spi_rx;
  logic        done;
  logic        error;
  logic [15:0] wr_count;

  always #10 clk = ~clk;

  aai_word_prog #(
    .ADDR_BYTES (3),
    .LEN_W      (16),
    .POLL_LIMIT (LIM),
    .BUSY_BIT   (0)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .length(length), .din_valid(din_valid), .din_ready(din_ready),
    .din_byte(din_byte), .spi_valid(spi_valid), .spi_ready(spi_ready),
    .spi_tx(spi_tx), .spi_end(spi_end), .spi_rx(spi_rx), .done(done),
    .error(error), .wr_count(wr_count)
  );

  int nchk = 0;
  int nfail = 0;

  // Flash model and payload source.
  int        cyc = 0;
  int        din_idx = 0;
  int        cur_len = 0;
  int        busy_left = 0;
  int        cur_p = 0;
  int        seed = 0;
  bit        src_on = 1'b0;
  logic [7:0] cur [8];
  int        fl = 0;
  logic [7:0] log_b [256][8];
  int        log_n [256];
  int        nlog = 0;

  function automatic logic [7:0] dat(input int s, input int k);
    return 8'(k * 37 + s * 11 + 8'h5A);
  endfunction

  assign din_valid = src_on && (din_idx < cur_len);
  assign din_byte  = dat(seed, din_idx);
  assign spi_rx    = {7'b0, busy_left != 0};

  always @(negedge clk) begin
    cyc <= cyc + 1;
    spi_ready <= ((cyc % 3) != 1);
  end

  always @(posedge clk) begin
    if (rst_n && spi_valid && spi_ready) begin
      if (fl < 8) cur[fl] = spi_tx;
      fl = fl + 1;
      if (spi_end) begin
        if (nlog < 256) begin
          for (int i = 0; i < 8; i++) log_b[nlog][i] = cur[i];
          log_n[nlog] = fl;
          nlog = nlog + 1;
        end
        if (cur[0] == 8'h05 && busy_left != 0) busy_left <= busy_left - 1;
        if (cur[0] == 8'h02 || cur[0] == 8'hAD) busy_left <= cur_p;
        fl = 0;
      end
    end
    if (rst_n && din_valid && din_ready) din_idx <= din_idx + 1;
  end

  // Expected frames, built from the requirements.
  logic [7:0] exp_b [256][8];
  int         exp_n [256];
  int         ne;
  int         exp_k;
  bit         exp_abort;

  task automatic push(input int n, input logic [7:0] b0, b1, b2, b3, b4, b5);
    if (exp_abort || ne >= 256) return;
    exp_b[ne][0] = b0; exp_b[ne][1] = b1; exp_b[ne][2] = b2;
    exp_b[ne][3] = b3; exp_b[ne][4] = b4; exp_b[ne][5] = b5;
    exp_b[ne][6] = 8'h00; exp_b[ne][7] = 8'h00;
    exp_n[ne] = n;
    ne = ne + 1;
  endtask

  task automatic polls(input int n);
    int m;
    m = (n > LIM) ? LIM : n;
    for (int i = 0; i < m; i++) push(2, 8'h05, 8'h00, 0, 0, 0, 0);
    if (n > LIM) exp_abort = 1'b1;
  endtask

  task automatic build(input logic [23:0] a0, input int l0, input int p);
    logic [23:0] a;
    int l;
    bit first;
    ne = 0; exp_k = 0; exp_abort = 1'b0;
    a = a0; l = l0; first = 1'b1;
    if (l0 == 0) return;
    polls(1);
    push(1, 8'h06, 0, 0, 0, 0, 0);
    if (a[0]) begin
      push(5, 8'h02, a[23:16], a[15:8], a[7:0], dat(seed, exp_k), 0);
      if (!exp_abort) exp_k++;
      polls(p + 1);
      a = a + 1; l = l - 1;
    end
    while (l >= 2 && !exp_abort) begin
      if (first)
        push(6, 8'hAD, a[23:16], a[15:8], a[7:0], dat(seed, exp_k), dat(seed, exp_k + 1));
      else
        push(3, 8'hAD, dat(seed, exp_k), dat(seed, exp_k + 1), 0, 0, 0);
      exp_k += 2;
      polls(p + 1);
      first = 1'b0; a = a + 2; l = l - 2;
    end
    push(1, 8'h04, 0, 0, 0, 0, 0);
    polls(1);
    if (l == 1 && !exp_abort) begin
      push(1, 8'h06, 0, 0, 0, 0, 0);
      push(5, 8'h02, a[23:16], a[15:8], a[7:0], dat(seed, exp_k), 0);
      exp_k++;
      polls(p + 1);
      push(1, 8'h04, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] pk(input int n, input logic [7:0] b [8]);
    logic [71:0] v;
    v = {8'(n), 64'h0};
    for (int i = 0; i < 8; i++) if (i < n) v[63-8*i -: 8] = b[i];
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] op, input int idx, input int total);
    case (op)
      8'h05: return "R5";
      8'h06: return (idx < 2) ? "R2" : "R7";
      8'h02: return (idx < 3) ? "R3" : "R7";
      8'hAD: return "R4";
      8'h04: return (idx + 2 < total) ? "R6" : "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic run(input logic [23:0] a, input int l, input int p, input bit poke);
    int w;
    int dcount;
    bit seen;
    bit err_s;
    int nl_done;
    @(negedge clk);
    seed = seed + 1;
    nlog = 0; fl = 0;
    busy_left = 0; cur_p = p;
    din_idx = 0; cur_len = l; src_on = 1'b1;
    build(a, l, p);
    start_addr = a; length = 16'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0; dcount = 0; seen = 1'b0; err_s = 1'b0;
    while (!seen && w < 20000) begin
      if (done) begin
        seen = 1'b1; err_s = error; dcount++;
      end else begin
        if (poke && w == 6) begin
          start_addr = 24'hABCDEF; length = 16'd9; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
        w++;
      end
    end
    start = 1'b0;
    check(seen, "R9 done seen", 72'(seen), 72'd1);
    nl_done = nlog;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) dcount++;
    end
    check(dcount == 1, "R9 done width", 72'(dcount), 72'd1);
    check(nlog == nl_done, "R8 no frame after done", 72'(nlog), 72'(nl_done));
    check(nlog == ne, (l == 0) ? "R11 frame count" : (poke ? "R12 frame count" : "R2 frame count"),
          72'(nlog), 72'(ne));
    for (int i = 0; i < ne; i++) begin
      logic [71:0] av, ev;
      av = (i < nlog) ? pk(log_n[i], log_b[i]) : 72'h0;
      ev = pk(exp_n[i], exp_b[i]);
      check(av == ev, poke ? "R12 frame" : tag_of(exp_b[i][0], i, ne), av, ev);
    end
    check(err_s == exp_abort, "R8 error", 72'(err_s), 72'(exp_abort));
    check(wr_count == 16'(exp_k), "R10 wr_count", 72'(wr_count), 72'(exp_k));
    check(din_idx == exp_k, "R13 payload consumed", 72'(din_idx), 72'(exp_k));
    src_on = 1'b0;
  endtask

  // {address, length, busy polls per program step}
  localparam logic [47:0] VEC [10] = '{
    {24'h000100, 16'd4, 8'd1},
    {24'h000101, 16'd5, 8'd0},
    {24'h0000FE, 16'd3, 8'd2},
    {24'h123457, 16'd1, 8'd1},
    {24'h000010, 16'd1, 8'd0},
    {24'h00FFFF, 16'd6, 8'd1},
    {24'h000000, 16'd0, 8'd0},
    {24'h0000AA, 16'd2, 8'd3},
    {24'h000201, 16'd3, 8'd20},
    {24'h000300, 16'd4, 8'd9}
  };

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!spi_valid && !din_ready && !done && !error, "R1 idle outputs",
          72'({spi_valid, din_ready, done, error}), 72'd0);
    check(wr_count == 0, "R1 wr_count", 72'(wr_count), 72'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!spi_valid && !done, "R1 idle after release", 72'({spi_valid, done}), 72'd0);

    foreach (VEC[i]) run(VEC[i][47:24], int'(VEC[i][23:8]), int'(VEC[i][7:0]), 1'b0);

    // R12: start raised mid-run is ignored
    run(24'h000041, 16'd4, 1, 1'b1);
    // R3/R7 together after a previous abort: clean restart
    run(24'h000033, 16'd2, 0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule